// File: doc/BRIEF.md
# Triggered Start Gate for Converter Sample Data

This block decides when converter samples start to move from the link side of a receive path to the application side. Normally it is open, and each beat of samples, with its valid flag, is registered and passed on one clock later. Software arms it with a single-cycle control pulse. From the next cycle on, the gate closes: the output valid flag is forced low, the output data is zeroed, and a downstream reset is held high. Downstream logic can use that reset to clear itself and start fresh.

An external sync signal ends the wait. It shares the converter clock, so it is not passed through a synchronizer. The gate reopens on the first rising edge of that signal seen while it is armed. A rising edge means the signal is high in this cycle and was low in the previous one. Data then flows without further gating until software arms the gate again. An armed status output lets the register layer report whether the gate is still waiting for its trigger.

Top module: `trig_start_gate`

## Requirements
- R1: After reset, armed_o = 0, ds_rst_o = 0, out_valid_o = 0 and out_data_o = 0, and the gate is open.
- R2: While the gate is open, out_data_o and out_valid_o equal in_data_i and in_valid_i of the previous cycle, including beats whose valid flag is 0.
- R3: An arm_i pulse while open sets armed_o and ds_rst_o from the next cycle. The beat present in the arm cycle still passes. Later beats are blocked.
- R4: While armed, every output beat has out_valid_o = 0 and out_data_o = 0, and ds_rst_o = 1 and armed_o = 1 hold.
- R5: A rising edge on sync_i while armed clears armed_o and ds_rst_o in the next cycle. The beat in the edge cycle is blocked. The beat in the following cycle is the first one passed.
- R6: A sync_i level that stays high is not an edge. If sync_i is already high when the gate is armed, the gate stays armed until sync_i falls and rises again.
- R7: A rising edge on sync_i while the gate is open changes nothing. The gate stays open and data keeps passing.
- R8: An arm_i pulse while already armed has no effect. If it comes in the same cycle as a rising edge, the edge still releases the gate.
- R9: If arm_i and a rising edge of sync_i arrive together while the gate is open, the gate becomes armed and the edge is ignored.
- R10: Reset while armed returns the gate to the open, reset state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arm_i | input | 1 | Single-cycle arm request from the control register |
| sync_i | input | 1 | External trigger, synchronous to clk |
| in_data_i | input | DATA_W (64) | Incoming beat, NUM_CH x SMP_PER_BEAT samples of SMP_W bits |
| in_valid_i | input | 1 | Valid flag of the incoming beat |
| out_data_o | output | DATA_W (64) | Gated beat, zero while armed |
| out_valid_o | output | 1 | Gated valid flag |
| ds_rst_o | output | 1 | Downstream reset, high while armed |
| armed_o | output | 1 | Status: armed and waiting for the trigger |

## Verification
The bench targets the three cycles around arming and release. A design that blocks too early would drop the beat in the arm cycle. A design that releases too early would leak the beat in the edge cycle. A design that releases too late would lose the first beat after the edge. It also holds sync high across arming, to catch a gate that reacts to the level instead of the edge and so opens at once. Stray edges while open, repeated arm pulses, and arm pulses that coincide with an edge are all driven. These catch a gate that latches an early trigger, re-arms, or lets arming win over release.

// File: rtl/trig_gate_pkg.sv
package trig_gate_pkg;

    // State of the rising-edge detector on the trigger input
    typedef struct packed {
        logic prev;
    } edge_state_t;

    // State of the arm/release controller
    typedef struct packed {
        logic armed;
    } ctrl_state_t;

    localparam edge_state_t EDGE_RST = '{prev: 1'b0};
    localparam ctrl_state_t CTRL_RST = '{armed: 1'b0};

endpackage

// File: rtl/sync_rise_det.sv
module sync_rise_det
    import trig_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic rise_o
);

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_i;
        rise_o    = sync_i & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= EDGE_RST;
        else        st_q <= st_d;
    end

    AST_LEVEL_NOT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && rise_o) |=> (sync_i -> !rise_o)); // R6

endmodule

// File: rtl/gate_arm_ctrl.sv
module gate_arm_ctrl
    import trig_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic rise_i,
    output logic armed_o
);

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.armed) begin
            // already waiting: only a trigger edge matters
            if (rise_i) st_d.armed = 1'b0;
        end else begin
            // open: only an arm request matters
            if (arm_i) st_d.armed = 1'b1;
        end
        armed_o = st_q.armed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CTRL_RST;
        else        st_q <= st_d;
    end

    AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_o && arm_i) |=> armed_o); // R3
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && !rise_i) |=> armed_o); // R4
    AST_EDGE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && rise_i) |=> !armed_o); // R5
    AST_OPEN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_o && !arm_i) |=> !armed_o); // R7

endmodule

// File: rtl/gate_data_stage.sv
module gate_data_stage #(
    parameter int LANES  = 4,
    parameter int SMP_W  = 16,
    localparam int DATA_W = LANES * SMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              valid_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } beat_t;

    beat_t st_d, st_q;
    logic [DATA_W-1:0] masked;

    // one gated slice per sample lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign masked[g*SMP_W +: SMP_W] = open_i ? data_i[g*SMP_W +: SMP_W] : '0;
    end

    always_comb begin
        st_d       = st_q;
        st_d.data  = masked;
        st_d.valid = valid_i & open_i;
        data_o     = st_q.data;
        valid_o    = st_q.valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SHUT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !open_i |=> (!valid_o && data_o == '0)); // R4
    AST_OPEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        open_i |=> (valid_o == $past(valid_i) && data_o == $past(data_i))); // R2

endmodule

// File: rtl/trig_start_gate.sv
module trig_start_gate #(
    parameter int NUM_CH       = 2,
    parameter int SMP_PER_BEAT = 2,
    parameter int SMP_W        = 16,
    localparam int LANES  = NUM_CH * SMP_PER_BEAT,
    localparam int DATA_W = LANES * SMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              sync_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              in_valid_i,
    output logic [DATA_W-1:0] out_data_o,
    output logic              out_valid_o,
    output logic              ds_rst_o,
    output logic              armed_o
);

    logic rise;
    logic armed;

    sync_rise_det u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_i),
        .rise_o (rise)
    );

    gate_arm_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (arm_i),
        .rise_i  (rise),
        .armed_o (armed)
    );

    gate_data_stage #(
        .LANES (LANES),
        .SMP_W (SMP_W)
    ) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_i  (~armed),
        .data_i  (in_data_i),
        .valid_i (in_valid_i),
        .data_o  (out_data_o),
        .valid_o (out_valid_o)
    );

    assign ds_rst_o = armed;
    assign armed_o  = armed;

    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (!armed_o && !ds_rst_o && !out_valid_o)); // R1

endmodule

// File: tb/trig_start_gate_tb.sv
module trig_start_gate_tb;

    localparam int DATA_W = 64;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              arm_i;
    logic              sync_i;
    logic [DATA_W-1:0] in_data_i;
    logic              in_valid_i;
    logic [DATA_W-1:0] out_data_o;
    logic              out_valid_o;
    logic              ds_rst_o;
    logic              armed_o;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;   // 250 MHz

    trig_start_gate u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (arm_i),
        .sync_i      (sync_i),
        .in_data_i   (in_data_i),
        .in_valid_i  (in_valid_i),
        .out_data_o  (out_data_o),
        .out_valid_o (out_valid_o),
        .ds_rst_o    (ds_rst_o),
        .armed_o     (armed_o)
    );

    // pass = gate open during this beat; armed = state after the beat
    typedef struct packed {
        logic        arm;
        logic        sync;
        logic        vld;
        logic [15:0] tag;
        logic        pass;
        logic        armed;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 16'hA001, 1'b1, 1'b0, 4'd2},  // R2 open
        '{1'b0, 1'b0, 1'b0, 16'hA002, 1'b1, 1'b0, 4'd2},  // R2 invalid beat passes data
        '{1'b0, 1'b1, 1'b1, 16'hA003, 1'b1, 1'b0, 4'd7},  // R7 stray edge while open
        '{1'b0, 1'b0, 1'b1, 16'hA004, 1'b1, 1'b0, 4'd7},  // R7 still open
        '{1'b1, 1'b0, 1'b1, 16'hA005, 1'b1, 1'b1, 4'd3},  // R3 arm, beat passes
        '{1'b0, 1'b0, 1'b1, 16'hA006, 1'b0, 1'b1, 4'd4},  // R4 blocked
        '{1'b1, 1'b0, 1'b1, 16'hA007, 1'b0, 1'b1, 4'd8},  // R8 re-arm no effect
        '{1'b0, 1'b1, 1'b1, 16'hA008, 1'b0, 1'b0, 4'd5},  // R5 edge beat blocked
        '{1'b0, 1'b1, 1'b1, 16'hA009, 1'b1, 1'b0, 4'd5},  // R5 first passed beat
        '{1'b1, 1'b1, 1'b1, 16'hA00A, 1'b1, 1'b1, 4'd6},  // R6 arm with sync high
        '{1'b0, 1'b1, 1'b1, 16'hA00B, 1'b0, 1'b1, 4'd6},  // R6 level is no edge
        '{1'b0, 1'b0, 1'b1, 16'hA00C, 1'b0, 1'b1, 4'd6},  // R6 falls
        '{1'b0, 1'b1, 1'b1, 16'hA00D, 1'b0, 1'b0, 4'd6},  // R6 new rise releases
        '{1'b0, 1'b0, 1'b1, 16'hA00E, 1'b1, 1'b0, 4'd5},  // R5 open again
        '{1'b1, 1'b1, 1'b1, 16'hA00F, 1'b1, 1'b1, 4'd9},  // R9 arm + edge while open
        '{1'b0, 1'b0, 1'b1, 16'hA010, 1'b0, 1'b1, 4'd9},  // R9 stays armed
        '{1'b1, 1'b1, 1'b1, 16'hA011, 1'b0, 1'b0, 4'd8},  // R8 arm + edge while armed
        '{1'b0, 1'b0, 1'b1, 16'hA012, 1'b1, 1'b0, 4'd8}   // R8 released
    };

    task automatic check(input int req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input int req, input logic ev,
                               input logic [DATA_W-1:0] ed, input logic ea);
        check(req, "out_valid_o", {63'd0, out_valid_o}, {63'd0, ev});
        check(req, "out_data_o", out_data_o, ed);
        check(req, "armed_o", {63'd0, armed_o}, {63'd0, ea});
        check(req, "ds_rst_o", {63'd0, ds_rst_o}, {63'd0, ea});
    endtask

    initial begin : watchdog
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; arm_i = 1'b0; sync_i = 1'b0;
        in_data_i = '0; in_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_state(1, 1'b0, '0, 1'b0);

        // table walk: drive at negedge, check one cycle later at negedge
        for (int k = 0; k < NV; k++) begin
            arm_i      = VECS[k].arm;
            sync_i     = VECS[k].sync;
            in_valid_i = VECS[k].vld;
            in_data_i  = {4{VECS[k].tag}};
            @(negedge clk);
            check_state(int'(VECS[k].req), VECS[k].vld & VECS[k].pass,
                        VECS[k].pass ? {4{VECS[k].tag}} : '0, VECS[k].armed);
        end

        // R10: reset while armed
        arm_i = 1'b1; sync_i = 1'b0; in_valid_i = 1'b1; in_data_i = {4{16'hB001}};
        @(negedge clk);
        arm_i = 1'b0;
        check_state(10, 1'b1, {4{16'hB001}}, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_state(10, 1'b0, '0, 1'b0);
        in_data_i = {4{16'hB002}};
        @(negedge clk);
        check_state(10, 1'b1, {4{16'hB002}}, 1'b0);

        // R4: long wait stays blocked with valid input every cycle
        arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
        for (int k = 0; k < 20; k++) begin
            in_data_i = {4{16'hC000 + 16'(k)}};
            @(negedge clk);
            check_state(4, 1'b0, '0, 1'b1);
        end
        sync_i = 1'b1;
        @(negedge clk);
        check_state(5, 1'b0, '0, 1'b0);
        in_data_i = {4{16'hC0FF}};
        @(negedge clk);
        check_state(5, 1'b1, {4{16'hC0FF}}, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule